// File: doc/BRIEF.md
# Serially Programmed Three-Input Lookup Table

This block is a small programmable logic element. Its three logic inputs can compute any Boolean function, because the truth table is held in eight configuration bits. Each bit gives the result for one input combination. The live table is fed from a shift stage. Configuration bits enter that stage one at a time on a serial data pin, and each bit advances on a clock edge where the shift enable is high. The output does not change while new bits arrive. The staged pattern takes effect only when a separate latch strobe copies it into the live table.

The last bit of the shift stage appears on a serial output pin. That pin can feed the serial input of the next table, so one programming stream can configure a whole column of tables. The bits sent first end up in the table farthest along the chain. An active-low clear resets both the staged bits and the live bits at once, without waiting for a clock edge. The clear input must be held high in normal operation.

The select width is a parameter: three by default, giving eight table bits. A second parameter picks how the select is built, either as a binary tree of 2-to-1 stages or as a single indexed read.

Top module: `serial_lut3`

## Requirements
- R1: The output equals bit k of the live pattern, where k is the unsigned value of the three-bit select (bit 0 of the select is the least significant). The output is combinational in the select.
- R2: On a rising clock edge with shift enable high, the shift stage moves up by one place. Bit i takes the value of bit i-1, and bit 0 takes the serial input. After eight shifts, the first bit sent sits in bit 7, so a pattern is sent most significant bit first.
- R3: On a rising clock edge with the latch strobe high, the live pattern takes the shift stage contents held just before that edge. This holds even when shift enable is high in the same cycle.
- R4: Shifting without a latch strobe leaves the output unchanged for every select value.
- R5: The serial output always shows bit 7 of the shift stage. It changes only on a shift edge or a clear.
- R6: When two tables are chained (serial output to serial input, shared shift and latch), sixteen shifts followed by one latch load the first eight bits sent into the second table and the last eight into the first.
- R7: While the clear is low, the shift stage and the live pattern are zero at once, without a clock edge. The output and the serial output are 0, and shift and latch strobes have no effect.
- R8: A clock edge with neither shift enable nor latch strobe high changes neither the output nor the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for shifting and latching |
| rst_n | input | 1 | Asynchronous clear, active low |
| cfg_shift | input | 1 | Shift enable for the configuration stage |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_latch | input | 1 | Copies the shift stage into the live table |
| cfg_sdo | output | 1 | Serial configuration data out (bit 7 of the shift stage) |
| lut_sel | input | 3 | Logic inputs that select one table bit |
| lut_out | output | 1 | Selected table bit |

## Verification
The bench loads patterns that are not symmetric, so a reversed shift direction or a select index read from the wrong end gives the wrong output on most select values. It also loads new bits without a latch while sweeping the select; a table that followed the shift stage directly would show the new pattern too early. One cycle has shift and latch high together, which catches a latch that picks up the post-shift contents. A clear is applied mid-cycle with the strobes held high, which exposes a clear that waits for the clock. A two-table chain shows whether the bits sent first end up in the far table.

// File: rtl/lut_cfg_pkg.sv
package lut_cfg_pkg;

   typedef enum logic [0:0] {
      SEL_TREE  = 1'b0,
      SEL_INDEX = 1'b1
   } sel_style_e;

   localparam int unsigned SEL_W_MIN = 1;
   localparam int unsigned SEL_W_MAX = 6;

   function automatic int unsigned table_bits(input int unsigned sel_w);
      return 32'd1 << sel_w;
   endfunction

endpackage

// File: rtl/lut_shift_stage.sv
module lut_shift_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q,
   output logic             ser_out
);

   if (WIDTH < 2) begin : g_bad_width
      $error("lut_shift_stage: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (shift_en) begin
         stage_q <= {stage_q[WIDTH-2:0], ser_in};
      end
   end

   assign ser_out = stage_q[WIDTH-1];

endmodule

// File: rtl/lut_live_stage.sv
module lut_live_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] stage_d,
   output logic [WIDTH-1:0] live_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (load) begin
         live_q <= stage_d;
      end
   end

endmodule

// File: rtl/lut_select.sv
module lut_select
   import lut_cfg_pkg::*;
#(
   parameter int unsigned SEL_W = 3,
   parameter sel_style_e  STYLE = SEL_TREE,
   localparam int unsigned DEPTH = 1 << SEL_W
) (
   input  logic [DEPTH-1:0] table_bits_i,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_o
);

   if (STYLE == SEL_INDEX) begin : g_index
      assign bit_o = table_bits_i[sel];
   end else begin : g_tree
      // Heap-ordered tree: node i has children 2i+1 and 2i+2.
      // Leaves sit at DEPTH-1+k; the root decides on the top select bit.
      localparam int unsigned NODES = 2 * DEPTH - 1;
      logic [NODES-1:0] node;

      for (genvar k = 0; k < DEPTH; k++) begin : g_leaf
         assign node[DEPTH-1+k] = table_bits_i[k];
      end

      for (genvar lvl = 0; lvl < SEL_W; lvl++) begin : g_level
         for (genvar j = 0; j < (1 << lvl); j++) begin : g_node
            localparam int unsigned IDX = (1 << lvl) - 1 + j;
            assign node[IDX] = sel[SEL_W-1-lvl] ? node[2*IDX+2] : node[2*IDX+1];
         end
      end

      assign bit_o = node[0];
   end

endmodule

// File: rtl/serial_lut3.sv
module serial_lut3
   import lut_cfg_pkg::*;
#(
   parameter int unsigned SEL_W = 3,
   parameter sel_style_e  STYLE = SEL_TREE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_shift,
   input  logic             cfg_sdi,
   input  logic             cfg_latch,
   output logic             cfg_sdo,
   input  logic [SEL_W-1:0] lut_sel,
   output logic             lut_out
);

   localparam int unsigned DEPTH = table_bits(SEL_W);

   if (SEL_W < SEL_W_MIN || SEL_W > SEL_W_MAX) begin : g_bad_sel
      $error("serial_lut3: SEL_W out of supported range");
   end

   logic [DEPTH-1:0] stage_q;
   logic [DEPTH-1:0] live_q;

   lut_shift_stage #(.WIDTH(DEPTH)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_shift),
      .ser_in   (cfg_sdi),
      .stage_q  (stage_q),
      .ser_out  (cfg_sdo)
   );

   lut_live_stage #(.WIDTH(DEPTH)) u_live (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_latch),
      .stage_d (stage_q),
      .live_q  (live_q)
   );

   lut_select #(.SEL_W(SEL_W), .STYLE(STYLE)) u_sel (
      .table_bits_i (live_q),
      .sel          (lut_sel),
      .bit_o        (lut_out)
   );

endmodule

// File: rtl/serial_lut3_chk.sv
module serial_lut3_chk #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned DEPTH = 1 << SEL_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_shift,
   input logic             cfg_sdi,
   input logic             cfg_latch,
   input logic             cfg_sdo,
   input logic [SEL_W-1:0] lut_sel,
   input logic             lut_out,
   input logic [DEPTH-1:0] stage_q,
   input logic [DEPTH-1:0] live_q
);

   // R2
   shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_shift |=> stage_q[0] == $past(cfg_sdi));

   // R3
   latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_latch |=> live_q == $past(stage_q));

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_latch |=> (!$stable(lut_sel) || $stable(lut_out)));

   // R5
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_shift |=> $stable(cfg_sdo));

   // R1
   select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lut_out == live_q[lut_sel]);

   // R7
   always @(negedge clk) begin
      if (!rst_n) begin
         clear_zero_chk: assert (lut_out == 1'b0 && cfg_sdo == 1'b0 && live_q == '0);
      end
   end

endmodule

bind serial_lut3 serial_lut3_chk #(.SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_shift (cfg_shift),
   .cfg_sdi   (cfg_sdi),
   .cfg_latch (cfg_latch),
   .cfg_sdo   (cfg_sdo),
   .lut_sel   (lut_sel),
   .lut_out   (lut_out),
   .stage_q   (stage_q),
   .live_q    (live_q)
);

// File: tb/sim_serial_lut3.sv
`timescale 1ns/1ps
module sim_serial_lut3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_shift = 1'b0;
   logic       cfg_sdi = 1'b0;
   logic       cfg_latch = 1'b0;
   logic [2:0] lut_sel = 3'd0;
   logic       sdo0, sdo1, out0, out1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // model state: queues of bits, index 0 = stage bit 0
   bit m_stage0[$];
   bit m_stage1[$];
   bit m_live0[8];
   bit m_live1[8];

   always #10 clk = ~clk;

   serial_lut3 u0 (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
      .cfg_latch(cfg_latch), .cfg_sdo(sdo0), .lut_sel(lut_sel), .lut_out(out0)
   );

   serial_lut3 u1 (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_sdi(sdo0),
      .cfg_latch(cfg_latch), .cfg_sdo(sdo1), .lut_sel(lut_sel), .lut_out(out1)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic model_clear();
      m_stage0.delete(); m_stage1.delete();
      for (int i = 0; i < 8; i++) begin
         m_stage0.push_back(1'b0); m_stage1.push_back(1'b0);
         m_live0[i] = 1'b0; m_live1[i] = 1'b0;
      end
   endtask

   task automatic compare_all(input string req);
      check(out0, m_live0[lut_sel], req);
      check(out1, m_live1[lut_sel], req);
      check(sdo0, m_stage0[7], req);
      check(sdo1, m_stage1[7], req);
   endtask

   // one clock cycle: drive at negedge, compare, model the posedge
   task automatic cyc(input bit sh, input bit d, input bit la, input logic [2:0] s,
                      input string req);
      bit carry;
      cfg_shift = sh; cfg_sdi = d; cfg_latch = la; lut_sel = s;
      #2;
      compare_all(req);
      @(posedge clk);
      if (la) begin
         for (int i = 0; i < 8; i++) begin
            m_live0[i] = m_stage0[i];
            m_live1[i] = m_stage1[i];
         end
      end
      if (sh) begin
         carry = m_stage0[7];
         void'(m_stage0.pop_back()); m_stage0.push_front(d);
         void'(m_stage1.pop_back()); m_stage1.push_front(carry);
      end
      @(negedge clk);
   endtask

   task automatic load_byte(input logic [7:0] pat, input string req);
      for (int b = 7; b >= 0; b--) cyc(1'b1, pat[b], 1'b0, 3'(b), req);
   endtask

   task automatic sweep(input string req);
      for (int s = 0; s < 8; s++) cyc(1'b0, 1'b0, 1'b0, 3'(s), req);
   endtask

   task automatic expect_live(input logic [7:0] p0, input logic [7:0] p1, input string req);
      for (int s = 0; s < 8; s++) begin
         lut_sel = 3'(s);
         #1;
         check(out0, p0[s], req);
         check(out1, p1[s], req);
      end
   endtask

   initial begin
      model_clear();
      #3;
      // R7: outputs cleared before any clock edge
      check(out0, 1'b0, "R7 reset out");
      check(sdo0, 1'b0, "R7 reset sdo");
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R4 R5: shift in 8'hB4 without latch
      load_byte(8'hB4, "R4 R5 shift no latch");
      // R1 R3: latch then sweep select
      cyc(1'b0, 1'b0, 1'b1, 3'd0, "R3 latch");
      expect_live(8'hB4, 8'h00, "R1 R2 table B4");
      sweep("R1 sweep");

      // R4: new pattern staged, live unchanged
      load_byte(8'h69, "R4 staged 69");
      expect_live(8'hB4, 8'h00, "R4 live still B4");

      // R8: idle cycles
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 3'(i * 3), "R8 idle");

      // R3: shift and latch together take pre-edge contents (69)
      cyc(1'b1, 1'b1, 1'b1, 3'd5, "R3 shift+latch");
      expect_live(8'h69, 8'hB4, "R3 pre-edge copy");

      // R7: clear mid-cycle while strobes held
      cfg_shift = 1'b1; cfg_latch = 1'b1; cfg_sdi = 1'b1; lut_sel = 3'd0;
      #3;
      rst_n = 1'b0;
      #1;
      model_clear();
      compare_all("R7 async clear");
      @(posedge clk); #1;
      compare_all("R7 strobes ignored");
      @(negedge clk);
      rst_n = 1'b1;

      // R6: chain of two, 16 shifts then latch
      load_byte(8'hC3, "R6 chain first");
      load_byte(8'h5A, "R6 chain second");
      cyc(1'b0, 1'b0, 1'b1, 3'd1, "R6 latch");
      expect_live(8'h5A, 8'hC3, "R6 chain placement");
      sweep("R6 sweep");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule